// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a single-port synchronous static RAM with registered inputs and a registered read output. It is meant for a chip that needs a small, cycle-accurate model of a burst-capable SRAM. The default array holds 256 words. Each word is 36 bits wide and is split into four lanes. A lane holds eight data bits plus one parity bit.

An access starts on a clock edge where either of two address strobes is low. On that edge the block captures the address and the three chip-select inputs. One strobe belongs to a processor and the other to a controller. The processor strobe wins when both are active, and a cycle it starts is always a read. On the edges that follow, the advance input steps an internal two-bit burst counter, which wraps within a group of four words. The counter follows either a linear or an interleaved order.

Writes are captured on one edge and committed to the array on the next edge. A global write stores every lane. Otherwise, when the byte-write enable is low, each lane is written only if its own control is low. Read data reaches the output register one edge after its address is registered. The output enable gates the output drivers asynchronously. The drivers are also forced off whenever a write is pending, after a deselect, and during sleep.

Top module: `sync_burst_sram`

## Requirements
- R1: An access is captured only on an edge where `strb_proc_n` or `strb_ctrl_n` is low. The chip counts as selected only when `sel1_n` is 0, `sel2` is 1 and `sel3_n` is 0 on that edge. Any other combination is a deselect.
- R2: When both strobes are low, the processor strobe takes precedence. A cycle started by `strb_proc_n` is a read: the write controls on that edge do not change the array.
- R3: With `gwr_n` low, all four lanes are written, whatever `bwr_en_n` and `bwr_n` are.
- R4: With `gwr_n` high and `bwr_en_n` low, lane k (bits 9k+8 down to 9k) is written only when `bwr_n[k]` is 0. If no lane is enabled, the cycle is a read.
- R5: For a read started on strobe edge N (with no advance), the word is on `q_out` and `q_drv` is high after edge N+1.
- R6: The burst counter advances on each non-strobe edge where `adv_n` is low and holds where `adv_n` is high. The burst offset is base+n mod 4 when `lin_order` is 1, and base XOR n when it is 0, where base is address bits 1:0. The upper address bits stay fixed.
- R7: `oe_n` high turns `q_drv` off without waiting for a clock edge, and `oe_n` low turns it back on.
- R8: While a captured write is pending for commit, `q_drv` is low, even with `oe_n` low.
- R9: After a write cycle, reads that continue the burst do not drive the output. `q_drv` stays low until a read is started by a strobe.
- R10: After a deselect edge, `q_drv` is low from the following edge on. Advance and write inputs are ignored until the next selected strobe.
- R11: While `sleep` is high, `q_drv` is low at once and all synchronous inputs are ignored. After sleep ends, the output stays off until a new strobe read.
- R12: Reset (`rst_n` low) turns `q_drv` off at once and ends any burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | AW (8) | Word address, captured on a strobe edge |
| strb_proc_n | input | 1 | Processor address strobe, active low, higher priority |
| strb_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| gwr_n | input | 1 | Global write of all lanes, active low |
| bwr_en_n | input | 1 | Byte-write enable, active low |
| bwr_n | input | 4 | Per-lane write selects, active low |
| lin_order | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| d_in | input | 36 | Write data, four 9-bit lanes |
| q_out | output | 36 | Read data from the output register |
| q_drv | output | 1 | Drive enable for the external tri-state buffers |

## Verification
Some rules depend only on the inputs and one or two edges of history. These are checked by properties on every cycle:

- the output enable and sleep gating of the drivers;
- the off state one edge after a controller write;
- the off state two edges after a write or a deselect.

The other behaviours need a reference memory and a sequence of events, so only the bench scenarios show them:

- the lane merges for masked and global writes;
- the processor-strobe priority;
- both burst orders and the wrap;
- the rule that continuation reads stay silent after a write;
- that writes are ignored while deselected or asleep.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int unsigned SBS_LANES  = 4;
  localparam int unsigned SBS_LANE_W = 9;
  localparam int unsigned SBS_DW     = SBS_LANES * SBS_LANE_W;

  typedef logic [SBS_LANES-1:0] lane_mask_t;

  // offset of the n-th beat inside a 4-word burst group
  function automatic logic [1:0] burst_lo(input logic [1:0] base,
                                          input logic [1:0] cnt,
                                          input logic       lin);
    return lin ? (base + cnt) : (base ^ cnt);
  endfunction
endpackage

// File: rtl/sbs_burst_gen.sv
module sbs_burst_gen #(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          lin,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out
);
  import sbs_pkg::*;

  logic [AW-3:0] hi_q, hi_d;
  logic [1:0]    base_q, base_d;
  logic [1:0]    cnt_q, cnt_d;

  always_comb begin
    hi_d   = hi_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    if (load) begin
      hi_d   = addr_in[AW-1:2];
      base_d = addr_in[1:0];
      cnt_d  = 2'd0;
    end else if (step) begin
      cnt_d  = cnt_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      hi_q   <= hi_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  assign addr_out = {hi_q, burst_lo(base_q, cnt_q, lin)};
endmodule

// File: rtl/sbs_lane_ram.sv
module sbs_lane_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned W  = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] adr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[adr] <= wdata;
  end

  assign rdata = mem[adr];
endmodule

// File: rtl/sbs_ctrl.sv
module sbs_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic strb_proc_n,
  input  logic strb_ctrl_n,
  input  logic adv_n,
  input  logic chip_sel,
  input  logic wr_req,
  input  logic sleep,
  output logic load,
  output logic step,
  output logic act_d,
  output logic act_q,
  output logic wr_q,
  output logic rd_q,
  output logic q_vld
);
  logic sel_q, sel_d;
  logic wr_d, rd_d;
  logic rd_ok_q, rd_ok_d;
  logic start;
  logic strobe;

  assign strobe = !strb_proc_n || !strb_ctrl_n;

  always_comb begin
    sel_d   = sel_q;
    act_d   = 1'b0;
    wr_d    = 1'b0;
    rd_ok_d = rd_ok_q;
    load    = 1'b0;
    step    = 1'b0;
    start   = 1'b0;
    if (sleep) begin
      sel_d   = 1'b0;
      rd_ok_d = 1'b0;
    end else if (strobe) begin
      sel_d = chip_sel;
      if (chip_sel) begin
        load  = 1'b1;
        act_d = 1'b1;
        start = 1'b1;
        wr_d  = strb_proc_n && wr_req;   // processor-started cycles read
      end else begin
        rd_ok_d = 1'b0;
      end
    end else if (sel_q) begin
      act_d = 1'b1;
      step  = !adv_n;
      wr_d  = wr_req;
    end
    if (act_d) begin
      if (wr_d)       rd_ok_d = 1'b0;
      else if (start) rd_ok_d = 1'b1;
    end
    rd_d = act_d && !wr_d && rd_ok_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      act_q   <= 1'b0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      rd_ok_q <= 1'b0;
      q_vld   <= 1'b0;
    end else begin
      sel_q   <= sel_d;
      act_q   <= act_d;
      wr_q    <= wr_d;
      rd_q    <= rd_d;
      rd_ok_q <= rd_ok_d;
      q_vld   <= rd_q;
    end
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int unsigned AW = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           addr,
  input  logic                    strb_proc_n,
  input  logic                    strb_ctrl_n,
  input  logic                    adv_n,
  input  logic                    sel1_n,
  input  logic                    sel2,
  input  logic                    sel3_n,
  input  logic                    gwr_n,
  input  logic                    bwr_en_n,
  input  logic [3:0]              bwr_n,
  input  logic                    lin_order,
  input  logic                    oe_n,
  input  logic                    sleep,
  input  logic [35:0]             d_in,
  output logic [35:0]             q_out,
  output logic                    q_drv
);
  import sbs_pkg::*;

  localparam int unsigned LW = SBS_LANE_W;
  localparam int unsigned NL = SBS_LANES;
  localparam int unsigned DW = SBS_DW;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  logic       chip_sel;
  lane_mask_t mask_in, mask_q, mask_d;
  logic [DW-1:0] data_q, data_d;
  logic [DW-1:0] rd_word;
  logic [DW-1:0] q_q, q_d;
  logic [AW-1:0] cur_addr;
  logic load, step, act_d, act_q, wr_q, rd_q, q_vld;

  assign chip_sel = !sel1_n && sel2 && !sel3_n;

  always_comb begin
    if (!gwr_n)         mask_in = '1;
    else if (!bwr_en_n) mask_in = ~bwr_n;
    else                mask_in = '0;
  end

  sbs_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_i_n),
    .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n),
    .adv_n(adv_n), .chip_sel(chip_sel), .wr_req(|mask_in),
    .sleep(sleep), .load(load), .step(step), .act_d(act_d),
    .act_q(act_q), .wr_q(wr_q), .rd_q(rd_q), .q_vld(q_vld)
  );

  sbs_burst_gen #(.AW(AW)) burst_i (
    .clk(clk), .rst_n(rst_i_n), .load(load), .step(step),
    .lin(lin_order), .addr_in(addr), .addr_out(cur_addr)
  );

  // write-stage registers, loaded only on active cycles
  always_comb begin
    mask_d = mask_q;
    data_d = data_q;
    if (act_d) begin
      mask_d = mask_in;
      data_d = d_in;
    end
    q_d = q_q;
    if (rd_q) q_d = rd_word;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      mask_q <= '0;
      data_q <= '0;
      q_q    <= '0;
    end else begin
      mask_q <= mask_d;
      data_q <= data_d;
      q_q    <= q_d;
    end
  end

  for (genvar l = 0; l < NL; l++) begin : g_lane
    sbs_lane_ram #(.AW(AW), .W(LW)) ram_i (
      .clk(clk),
      .we(act_q && wr_q && mask_q[l]),
      .adr(cur_addr),
      .wdata(data_q[l*LW +: LW]),
      .rdata(rd_word[l*LW +: LW])
    );
  end

  assign q_out = q_q;
  assign q_drv = q_vld && !oe_n && !(act_q && wr_q) && !sleep;
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       strb_proc_n,
  input logic       strb_ctrl_n,
  input logic       sel1_n,
  input logic       sel2,
  input logic       sel3_n,
  input logic       gwr_n,
  input logic       bwr_en_n,
  input logic [3:0] bwr_n,
  input logic       oe_n,
  input logic       sleep,
  input logic       q_drv
);
  logic cs, wr_ask;
  assign cs     = !sel1_n && sel2 && !sel3_n;
  assign wr_ask = !gwr_n || (!bwr_en_n && !(&bwr_n));

  // R7
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !q_drv);

  // R11
  sleep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !q_drv);

  // R8
  wr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_proc_n && !strb_ctrl_n && cs && wr_ask && !sleep) |=> !q_drv);

  // R9
  wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_proc_n && !strb_ctrl_n && cs && wr_ask && !sleep) |-> ##2 !q_drv);

  // R10
  desel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!strb_proc_n || !strb_ctrl_n) && !cs) |-> ##2 !q_drv);
endmodule

bind sync_burst_sram sbs_checker chk_i (
  .clk(clk), .rst_n(rst_n), .strb_proc_n(strb_proc_n),
  .strb_ctrl_n(strb_ctrl_n), .sel1_n(sel1_n), .sel2(sel2),
  .sel3_n(sel3_n), .gwr_n(gwr_n), .bwr_en_n(bwr_en_n), .bwr_n(bwr_n),
  .oe_n(oe_n), .sleep(sleep), .q_drv(q_drv)
);

// File: tb/sync_burst_sram_tb_top.sv
`timescale 1ns/1ps
module sync_burst_sram_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr;
  logic        strb_proc_n, strb_ctrl_n, adv_n;
  logic        sel1_n, sel2, sel3_n;
  logic        gwr_n, bwr_en_n;
  logic [3:0]  bwr_n;
  logic        lin_order, oe_n, sleep;
  logic [35:0] d_in, q_out;
  logic        q_drv;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sync_burst_sram dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .strb_proc_n(strb_proc_n),
    .strb_ctrl_n(strb_ctrl_n), .adv_n(adv_n), .sel1_n(sel1_n),
    .sel2(sel2), .sel3_n(sel3_n), .gwr_n(gwr_n), .bwr_en_n(bwr_en_n),
    .bwr_n(bwr_n), .lin_order(lin_order), .oe_n(oe_n), .sleep(sleep),
    .d_in(d_in), .q_out(q_out), .q_drv(q_drv)
  );

  // flags: {proc, ctrl, adv, chip_sel, global_wr, byte_wr_en, linear}
  typedef struct packed {
    logic [6:0]  fl;
    logic [3:0]  bw;
    logic [7:0]  a;
    logic [35:0] d;
    logic        edrv;
    logic [35:0] eq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VEC [NV] = '{
    '{7'b0101101, 4'h0, 8'h10, 36'h1A1A1A1A1, 1'b0, 36'h0, 4'd3},  // R3 global write 10
    '{7'b0010101, 4'h0, 8'h00, 36'h2B2B2B2B2, 1'b0, 36'h0, 4'd6},  // R6 burst write 11
    '{7'b0010101, 4'h0, 8'h00, 36'h3D3D3D3D3, 1'b0, 36'h0, 4'd6},  // 12
    '{7'b0010101, 4'h0, 8'h00, 36'h4E4E4E4E4, 1'b0, 36'h0, 4'd6},  // 13
    '{7'b0101101, 4'h0, 8'h20, 36'h000000000, 1'b0, 36'h0, 4'd3},  // clear 20
    '{7'b0101011, 4'h5, 8'h20, 36'hFFFFFFFFF, 1'b0, 36'h0, 4'd4},  // R4 lanes 0,2
    '{7'b0101011, 4'h0, 8'h20, 36'h123456789, 1'b0, 36'h0, 4'd4},  // R4 no lane = read
    '{7'b0000001, 4'h0, 8'h00, 36'h0, 1'b1, 36'h007FC01FF, 4'd4},
    '{7'b1101101, 4'h0, 8'h10, 36'h000000000, 1'b1, 36'h007FC01FF, 4'd2}, // R2 both strobes
    '{7'b0010001, 4'h0, 8'h00, 36'h0, 1'b1, 36'h1A1A1A1A1, 4'd2},  // R2 untouched, R5
    '{7'b0010001, 4'h0, 8'h00, 36'h0, 1'b1, 36'h2B2B2B2B2, 4'd6},
    '{7'b0010001, 4'h0, 8'h00, 36'h0, 1'b1, 36'h3D3D3D3D3, 4'd6},
    '{7'b0010001, 4'h0, 8'h00, 36'h0, 1'b1, 36'h4E4E4E4E4, 4'd6},
    '{7'b0010001, 4'h0, 8'h00, 36'h0, 1'b1, 36'h1A1A1A1A1, 4'd6},  // R6 wrap
    '{7'b1001000, 4'h0, 8'h11, 36'h0, 1'b1, 36'h2B2B2B2B2, 4'd6},  // interleaved from 11
    '{7'b0010000, 4'h0, 8'h00, 36'h0, 1'b1, 36'h2B2B2B2B2, 4'd6},
    '{7'b0010000, 4'h0, 8'h00, 36'h0, 1'b1, 36'h1A1A1A1A1, 4'd6},
    '{7'b0010000, 4'h0, 8'h00, 36'h0, 1'b1, 36'h4E4E4E4E4, 4'd6},
    '{7'b0010000, 4'h0, 8'h00, 36'h0, 1'b1, 36'h3D3D3D3D3, 4'd6},
    '{7'b0101101, 4'h0, 8'h30, 36'h0F0F0F0F0, 1'b0, 36'h0, 4'd8},  // R8 write forces off
    '{7'b0010001, 4'h0, 8'h00, 36'h0, 1'b0, 36'h0, 4'd9},          // R9 silent continuation
    '{7'b0000001, 4'h0, 8'h00, 36'h0, 1'b0, 36'h0, 4'd9},
    '{7'b0101001, 4'h0, 8'h30, 36'h0, 1'b0, 36'h0, 4'd9},
    '{7'b0000001, 4'h0, 8'h00, 36'h0, 1'b1, 36'h0F0F0F0F0, 4'd5},  // R5
    '{7'b0100001, 4'h0, 8'h30, 36'h0, 1'b1, 36'h0F0F0F0F0, 4'd10}, // R10 deselect
    '{7'b0000001, 4'h0, 8'h00, 36'h0, 1'b0, 36'h0, 4'd10},
    '{7'b0000101, 4'h0, 8'h00, 36'hDEADBEEF0, 1'b0, 36'h0, 4'd10}, // ignored write
    '{7'b0101001, 4'h0, 8'h30, 36'h0, 1'b0, 36'h0, 4'd1},
    '{7'b0000001, 4'h0, 8'h00, 36'h0, 1'b1, 36'h0F0F0F0F0, 4'd10},
    '{7'b0101011, 4'h8, 8'h20, 36'hAAAAAAAAA, 1'b0, 36'h0, 4'd4},  // R4 lane 3
    '{7'b0101001, 4'h0, 8'h20, 36'h0, 1'b0, 36'h0, 4'd4},
    '{7'b0000001, 4'h0, 8'h00, 36'h0, 1'b1, 36'hAAFFC01FF, 4'd4},
    '{7'b0101111, 4'h1, 8'h21, 36'h5A5A5A5A5, 1'b0, 36'h0, 4'd3},  // R3 overrides bytes
    '{7'b0101001, 4'h0, 8'h21, 36'h0, 1'b0, 36'h0, 4'd3},
    '{7'b0000001, 4'h0, 8'h00, 36'h0, 1'b1, 36'h5A5A5A5A5, 4'd3}
  };

  task automatic chk(input bit ok, input int rq, input logic [35:0] act,
                     input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic idle_in();
    strb_proc_n = 1'b1; strb_ctrl_n = 1'b1; adv_n = 1'b1;
    sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0;
    gwr_n = 1'b1; bwr_en_n = 1'b1; bwr_n = 4'hF;
    addr = 8'h00; d_in = 36'h0;
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic drive(input vec_t v);
    strb_proc_n = !v.fl[6];
    strb_ctrl_n = !v.fl[5];
    adv_n       = !v.fl[4];
    sel1_n      = !v.fl[3];
    sel2        =  v.fl[3];
    sel3_n      = !v.fl[3];
    gwr_n       = !v.fl[2];
    bwr_en_n    = !v.fl[1];
    lin_order   =  v.fl[0];
    bwr_n       = ~v.bw;
    addr        = v.a;
    d_in        = v.d;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    idle_in();
    lin_order = 1'b1; oe_n = 1'b0; sleep = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #2;
    chk(q_drv == 1'b0, 12, {35'd0, q_drv}, 36'h0);  // R12 off in reset
    rst_n = 1'b1;
    repeat (3) step();
    chk(q_drv == 1'b0, 12, {35'd0, q_drv}, 36'h0);  // R12 off after release

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      step();
      chk(q_drv == VEC[i].edrv, VEC[i].req, {35'd0, q_drv}, {35'd0, VEC[i].edrv});
      if (VEC[i].edrv)
        chk(q_out == VEC[i].eq, VEC[i].req, q_out, VEC[i].eq);
    end

    // R7: asynchronous output enable while a read drives
    idle_in(); lin_order = 1'b1;
    oe_n = 1'b1; #1;
    chk(q_drv == 1'b0, 7, {35'd0, q_drv}, 36'h0);
    oe_n = 1'b0; #1;
    chk(q_drv == 1'b1, 7, {35'd0, q_drv}, 36'h1);

    // R11: deselect, sleep with an attempted write, wake up
    strb_ctrl_n = 1'b0; sel2 = 1'b0; step();
    idle_in(); step();
    sleep = 1'b1; #1;
    chk(q_drv == 1'b0, 11, {35'd0, q_drv}, 36'h0);
    strb_ctrl_n = 1'b0; gwr_n = 1'b0; addr = 8'h21; d_in = 36'h0; step();
    idle_in(); step();
    chk(q_drv == 1'b0, 11, {35'd0, q_drv}, 36'h0);
    sleep = 1'b0; step();
    chk(q_drv == 1'b0, 11, {35'd0, q_drv}, 36'h0);  // stays off after wake
    strb_ctrl_n = 1'b0; addr = 8'h21; step();
    idle_in(); step();
    chk(q_drv == 1'b1, 11, {35'd0, q_drv}, 36'h1);
    chk(q_out == 36'h5A5A5A5A5, 11, q_out, 36'h5A5A5A5A5);  // sleep write ignored

    // R1: only sel2 wrong -> deselect
    strb_ctrl_n = 1'b0; sel2 = 1'b0; addr = 8'h10; step();
    chk(q_drv == 1'b1, 1, {35'd0, q_drv}, 36'h1);
    idle_in(); step();
    chk(q_drv == 1'b0, 1, {35'd0, q_drv}, 36'h0);
    // R1: sel3_n wrong, also deselect; then a good select reads 10
    strb_proc_n = 1'b0; sel3_n = 1'b1; addr = 8'h10; step();
    idle_in(); step();
    chk(q_drv == 1'b0, 1, {35'd0, q_drv}, 36'h0);
    strb_proc_n = 1'b0; addr = 8'h10; step();
    idle_in(); step();
    chk(q_out == 36'h1A1A1A1A1 && q_drv, 1, q_out, 36'h1A1A1A1A1);

    // R12: reset turns drivers off at once
    rst_n = 1'b0; #1;
    chk(q_drv == 1'b0, 12, {35'd0, q_drv}, 36'h0);
    step();
    rst_n = 1'b1;

    done = 1'b1;
    finish_run();
  end
endmodule